// File: doc/BRIEF.md
# Active Priority Preemption Tracker

This block keeps track of nested interrupt activations for one CPU interface of an interrupt controller. Each time an interrupt is acknowledged, the block reduces the interrupt's 8-bit priority to a group priority using a binary point. It then marks the matching preemption level in one of two banked active-level bitmaps, one for secure (Group 0) activations and one for non-secure (Group 1) activations, and raises the running priority to that group priority.

On an end-of-interrupt, the block retires the most urgent active level of the interrupt's group. It then rebuilds the running priority from the lowest level still marked in either bitmap. With nothing active, the running priority holds an idle value of 0x100, which lies above every real priority.

The surrounding controller chooses which interrupt to acknowledge and decodes all register accesses. This block only sees single-cycle acknowledge and end-of-interrupt strobes, together with the configuration levels that qualify them. Each strobe takes effect on the next clock edge.

Top module: `apt_tracker`

## Requirements
- R1: After reset, running_prio is 0x100 and both active_s and active_ns are all zero.
- R2: An acknowledge forms the group priority as ack_prio AND (0xFF shifted left by bp+1, truncated to 8 bits). A binary point of 0 keeps bits [7:1] and 7 keeps none. On the next edge running_prio equals that group priority with bit 8 clear.
- R3: The binary point used is bpr_g1 when groups_en is 1, cbpr is 0 and ack_group is 1. In every other case bpr_g0 is used.
- R4: The acknowledged preemption level is group priority >> 4 (range 0..15), and bit [level] is set. The bit goes in active_ns when groups_en and ack_group are both 1, and in active_s otherwise.
- R5: After an accepted end-of-interrupt, running_prio equals (index of the lowest set bit of active_s OR active_ns) << 4. If both bitmaps are empty it is 0x100.
- R6: An accepted end-of-interrupt clears only the lowest set bit of its own group's bitmap. That bitmap is active_ns when groups_en and eoi_group are both 1, and active_s otherwise. The other bitmap is left unchanged.
- R7: An end-of-interrupt is ignored, leaving all outputs unchanged, while running_prio is 0x100.
- R8: An end-of-interrupt whose eoi_irq is at or above NUM_IRQ (default 96) is ignored.
- R9: When sec_ext is 1, an end-of-interrupt with eoi_secure 0 for a Group 0 interrupt is ignored. When sec_ext is 0 the same request is honoured.
- R10: With no strobe asserted, all outputs keep their values from one edge to the next.
- R11: When both strobes are asserted in one cycle, the end-of-interrupt is applied first and then the acknowledge's bit is set. running_prio then becomes the acknowledged group priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| groups_en | input | 1 | Interrupt grouping is supported |
| sec_ext | input | 1 | Security extensions are present |
| cbpr | input | 1 | Group 1 shares the Group 0 binary point |
| bpr_g0 | input | 3 | Main binary point |
| bpr_g1 | input | 3 | Group 1 binary point |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_prio | input | 8 | Priority of the acknowledged interrupt |
| ack_group | input | 1 | Acknowledged interrupt is Group 1 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_irq | input | 10 | Interrupt number named by the end-of-interrupt |
| eoi_group | input | 1 | Completed interrupt is Group 1 |
| eoi_secure | input | 1 | End-of-interrupt is a secure access |
| running_prio | output | 9 | Current running priority, 0x100 when idle |
| active_s | output | 32 | Group 0 active-level bitmap |
| active_ns | output | 32 | Group 1 active-level bitmap |

## Verification
The assertions rely on the configuration levels staying steady around a strobe. They also rely on both strobes lasting exactly one cycle. They do not rely on end-of-interrupts being properly nested with acknowledges: they check only that the idle value agrees with empty bitmaps, and that rejected or absent strobes leave the state untouched. The stimulus changes configuration only while no strobe is active. It holds each strobe for a single cycle, and it includes out-of-order and rejected completions so that the ignore paths are exercised.

// File: rtl/apt_pkg.sv
package apt_pkg;
    typedef enum logic {
        BANK_S  = 1'b0,
        BANK_NS = 1'b1
    } bank_e;

    localparam int BP_W = 3;
endpackage

// File: rtl/apt_group_prio.sv
module apt_group_prio
    import apt_pkg::*;
#(
    parameter int PRIO_W  = 8,
    parameter int MIN_BPR = 3,
    localparam int LVL_W  = PRIO_W - MIN_BPR - 1
) (
    input  logic [PRIO_W-1:0] prio,
    input  logic              group1,
    input  logic              groups_en,
    input  logic              cbpr,
    input  logic [BP_W-1:0]   bpr_g0,
    input  logic [BP_W-1:0]   bpr_g1,
    output logic [PRIO_W-1:0] gprio,
    output logic [LVL_W-1:0]  level,
    output bank_e             bank
);
    logic [BP_W-1:0]   bp;
    logic [BP_W:0]     shamt;
    logic [PRIO_W-1:0] mask;

    always_comb begin
        bp    = (groups_en && !cbpr && group1) ? bpr_g1 : bpr_g0;
        shamt = {1'b0, bp} + 1'b1;
        mask  = {PRIO_W{1'b1}} << shamt;
        gprio = prio & mask;
        level = gprio[PRIO_W-1 -: LVL_W];
        bank  = (groups_en && group1) ? BANK_NS : BANK_S;
    end
endmodule

// File: rtl/apt_lowest_set.sv
module apt_lowest_set #(
    parameter int W     = 32,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/apt_eoi_gate.sv
module apt_eoi_gate
    import apt_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int IRQ_W   = 10
) (
    input  logic             eoi_valid,
    input  logic [IRQ_W-1:0] eoi_irq,
    input  logic             eoi_group,
    input  logic             eoi_secure,
    input  logic             groups_en,
    input  logic             sec_ext,
    input  logic             run_idle,
    output logic             accept,
    output bank_e            bank
);
    logic in_range;
    logic g1;
    logic sec_block;

    always_comb begin
        in_range  = int'(eoi_irq) < NUM_IRQ;
        g1        = groups_en && eoi_group;
        sec_block = sec_ext && !eoi_secure && !g1;
        accept    = eoi_valid && in_range && !run_idle && !sec_block;
        bank      = g1 ? BANK_NS : BANK_S;
    end
endmodule

// File: rtl/apt_tracker.sv
module apt_tracker
    import apt_pkg::*;
#(
    parameter int PRIO_W  = 8,
    parameter int MIN_BPR = 3,
    parameter int WORD_W  = 32,
    parameter int NUM_IRQ = 96,
    parameter int IRQ_W   = 10,
    localparam int LVL_W     = PRIO_W - MIN_BPR - 1,
    localparam int LEVELS    = 1 << LVL_W,
    localparam int NUM_WORDS = (LEVELS + WORD_W - 1) / WORD_W,
    localparam int MAP_W     = NUM_WORDS * WORD_W,
    localparam int IDX_W     = $clog2(MAP_W),
    localparam int RUN_W     = PRIO_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              groups_en,
    input  logic              sec_ext,
    input  logic              cbpr,
    input  logic [BP_W-1:0]   bpr_g0,
    input  logic [BP_W-1:0]   bpr_g1,
    input  logic              ack_valid,
    input  logic [PRIO_W-1:0] ack_prio,
    input  logic              ack_group,
    input  logic              eoi_valid,
    input  logic [IRQ_W-1:0]  eoi_irq,
    input  logic              eoi_group,
    input  logic              eoi_secure,
    output logic [RUN_W-1:0]  running_prio,
    output logic [MAP_W-1:0]  active_s,
    output logic [MAP_W-1:0]  active_ns
);
    localparam logic [RUN_W-1:0] IDLE = RUN_W'(1) << PRIO_W;

    typedef struct packed {
        logic [MAP_W-1:0] map_s;
        logic [MAP_W-1:0] map_ns;
        logic [RUN_W-1:0] run;
    } state_t;

    state_t st_d, st_q;

    logic [PRIO_W-1:0] ack_gprio;
    logic [LVL_W-1:0]  ack_level;
    bank_e             ack_bank;
    logic              eoi_accept;
    bank_e             eoi_bank;
    logic [MAP_W-1:0]  s_after_eoi_d;
    logic [MAP_W-1:0]  ns_after_eoi_d;
    logic [IDX_W-1:0]  low_idx;
    logic              low_found;

    apt_group_prio #(.PRIO_W(PRIO_W), .MIN_BPR(MIN_BPR)) u_gprio (
        .prio(ack_prio), .group1(ack_group), .groups_en(groups_en),
        .cbpr(cbpr), .bpr_g0(bpr_g0), .bpr_g1(bpr_g1),
        .gprio(ack_gprio), .level(ack_level), .bank(ack_bank)
    );

    apt_eoi_gate #(.NUM_IRQ(NUM_IRQ), .IRQ_W(IRQ_W)) u_gate (
        .eoi_valid(eoi_valid), .eoi_irq(eoi_irq), .eoi_group(eoi_group),
        .eoi_secure(eoi_secure), .groups_en(groups_en), .sec_ext(sec_ext),
        .run_idle(st_q.run == IDLE), .accept(eoi_accept), .bank(eoi_bank)
    );

    // Retire the most urgent level of the completing group (clear lowest set bit).
    always_comb begin
        s_after_eoi_d  = st_q.map_s;
        ns_after_eoi_d = st_q.map_ns;
        if (eoi_accept) begin
            if (eoi_bank == BANK_NS) ns_after_eoi_d = st_q.map_ns & (st_q.map_ns - 1'b1);
            else                     s_after_eoi_d  = st_q.map_s  & (st_q.map_s  - 1'b1);
        end
    end

    apt_lowest_set #(.W(MAP_W)) u_low (
        .vec(s_after_eoi_d | ns_after_eoi_d), .idx(low_idx), .found(low_found)
    );

    always_comb begin
        st_d        = st_q;
        st_d.map_s  = s_after_eoi_d;
        st_d.map_ns = ns_after_eoi_d;
        if (eoi_accept) begin
            st_d.run = low_found ? (RUN_W'(low_idx) << (MIN_BPR + 1)) : IDLE;
        end
        if (ack_valid) begin
            if (ack_bank == BANK_NS) st_d.map_ns = ns_after_eoi_d | (MAP_W'(1) << ack_level);
            else                     st_d.map_s  = s_after_eoi_d  | (MAP_W'(1) << ack_level);
            st_d.run = {1'b0, ack_gprio};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.map_s  <= '0;
            st_q.map_ns <= '0;
            st_q.run    <= IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign running_prio = st_q.run;
    assign active_s     = st_q.map_s;
    assign active_ns    = st_q.map_ns;

    assert_idle_matches_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running_prio == IDLE) == ((active_s | active_ns) == '0));

    assert_ack_leaves_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> (running_prio[PRIO_W] == 1'b0) && ((active_s | active_ns) != '0));

    assert_eoi_idle_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_valid && running_prio == IDLE) |=>
            $stable(running_prio) && $stable(active_s) && $stable(active_ns));

    assert_eoi_range_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_valid && int'(eoi_irq) >= NUM_IRQ) |=>
            $stable(running_prio) && $stable(active_s) && $stable(active_ns));

    assert_eoi_ns_g0_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_valid && sec_ext && !eoi_secure && !(groups_en && eoi_group)) |=>
            $stable(active_s) && $stable(active_ns));

    assert_quiet_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_valid && !eoi_valid) |=>
            $stable(running_prio) && $stable(active_s) && $stable(active_ns));

    assert_eoi_retires_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_valid) |=>
            ($countones(active_s | active_ns) + 1 >= $past($countones(active_s | active_ns))));
endmodule

// File: tb/apt_tracker_test.sv
module apt_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        groups_en = 1'b0, sec_ext = 1'b0, cbpr = 1'b0;
    logic [2:0]  bpr_g0 = 3'd0, bpr_g1 = 3'd0;
    logic        ack_valid = 1'b0, ack_group = 1'b0;
    logic [7:0]  ack_prio = 8'd0;
    logic        eoi_valid = 1'b0, eoi_group = 1'b0, eoi_secure = 1'b1;
    logic [9:0]  eoi_irq = 10'd0;
    logic [8:0]  running_prio;
    logic [31:0] active_s, active_ns;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_s = 32'd0, m_ns = 32'd0;
    logic [8:0]  m_run = 9'h100;
    logic [15:0] lf = 16'hACE1;

    always #5 clk = ~clk;

    apt_tracker uut (
        .clk(clk), .rst_n(rst_n), .groups_en(groups_en), .sec_ext(sec_ext), .cbpr(cbpr),
        .bpr_g0(bpr_g0), .bpr_g1(bpr_g1), .ack_valid(ack_valid), .ack_prio(ack_prio),
        .ack_group(ack_group), .eoi_valid(eoi_valid), .eoi_irq(eoi_irq),
        .eoi_group(eoi_group), .eoi_secure(eoi_secure), .running_prio(running_prio),
        .active_s(active_s), .active_ns(active_ns)
    );

    function automatic logic [8:0] low_run(input logic [31:0] m);
        for (int i = 0; i < 32; i++) if (m[i]) return 9'(i << 4);
        return 9'h100;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        chk(tag, 32'(running_prio), 32'(m_run));
        chk(tag, active_s, m_s);
        chk(tag, active_ns, m_ns);
    endtask

    task automatic model_ack(input logic [7:0] p, input logic g);
        logic [2:0] bp;
        logic [7:0] gp;
        bp = (groups_en && !cbpr && g) ? bpr_g1 : bpr_g0;
        gp = p & 8'((16'hFF << (int'(bp) + 1)) & 16'hFF);
        if (groups_en && g) m_ns[gp >> 4] = 1'b1;
        else                m_s[gp >> 4]  = 1'b1;
        m_run = {1'b0, gp};
    endtask

    task automatic model_eoi(input logic [9:0] irq, input logic g, input logic sec);
        logic g1;
        g1 = groups_en && g;
        if (int'(irq) >= 96 || m_run == 9'h100 || (sec_ext && !sec && !g1)) return;
        if (g1) m_ns = m_ns & (m_ns - 1);
        else    m_s  = m_s & (m_s - 1);
        m_run = low_run(m_s | m_ns);
    endtask

    task automatic do_ack(input logic [7:0] p, input logic g, input string tag);
        @(negedge clk);
        ack_valid = 1'b1; ack_prio = p; ack_group = g;
        model_ack(p, g);
        @(negedge clk);
        ack_valid = 1'b0;
        check_state(tag);
    endtask

    task automatic do_eoi(input logic [9:0] irq, input logic g, input logic sec, input string tag);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_irq = irq; eoi_group = g; eoi_secure = sec;
        model_eoi(irq, g, sec);
        @(negedge clk);
        eoi_valid = 1'b0;
        check_state(tag);
    endtask

    task automatic drain();
        for (int k = 0; k < 40 && m_run != 9'h100; k++) begin
            if (m_s != 0) do_eoi(10'd1, 1'b0, 1'b1, "R6");
            else          do_eoi(10'd1, 1'b1, 1'b1, "R6");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_state("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1");

        // R2 / R4 sweep: every priority under every main binary point, groups off.
        for (int bp = 0; bp < 8; bp++) begin
            bpr_g0 = 3'(bp);
            for (int p = 0; p < 256; p++) begin
                do_ack(8'(p), 1'b0, "R2");
                do_eoi(10'd5, 1'b0, 1'b1, "R5");
            end
        end

        // R3: binary point selection under grouping / shared-point controls.
        for (int cfg = 0; cfg < 8; cfg++) begin
            groups_en = cfg[0]; cbpr = cfg[1];
            for (int b0 = 0; b0 < 8; b0++) begin
                for (int b1 = 0; b1 < 8; b1++) begin
                    bpr_g0 = 3'(b0); bpr_g1 = 3'(b1);
                    do_ack(cfg[2] ? 8'hA5 : 8'hFF, cfg[2], "R3");
                    do_eoi(10'd7, cfg[2], 1'b1, "R4");
                end
            end
        end

        groups_en = 1'b1; cbpr = 1'b0; bpr_g0 = 3'd3; bpr_g1 = 3'd3; sec_ext = 1'b1;

        // R7: completion with nothing active.
        do_eoi(10'd3, 1'b1, 1'b1, "R7");
        do_eoi(10'd3, 1'b0, 1'b1, "R7");

        // R8: out-of-range interrupt numbers.
        do_ack(8'h50, 1'b0, "R4");
        do_eoi(10'd96, 1'b0, 1'b1, "R8");
        do_eoi(10'd1023, 1'b0, 1'b1, "R8");
        chk("R8", 32'(running_prio), 32'h50);

        // R9: non-secure completion of Group 0.
        do_eoi(10'd2, 1'b0, 1'b0, "R9");
        chk("R9", active_s, 32'h20);
        do_eoi(10'd2, 1'b0, 1'b1, "R9");
        chk("R9", 32'(running_prio), 32'h100);
        sec_ext = 1'b0;
        do_ack(8'h30, 1'b0, "R4");
        do_eoi(10'd2, 1'b0, 1'b0, "R9");
        chk("R9", 32'(running_prio), 32'h100);

        // R6 / R5: nested levels in both banks; completion hits only its own bank.
        do_ack(8'hC0, 1'b0, "R4");
        do_ack(8'h80, 1'b1, "R4");
        do_ack(8'h40, 1'b0, "R4");
        do_ack(8'h20, 1'b1, "R4");
        do_eoi(10'd9, 1'b0, 1'b1, "R6");
        chk("R6", active_ns, 32'h0104);
        chk("R5", 32'(running_prio), 32'h20);
        do_eoi(10'd9, 1'b1, 1'b1, "R6");
        chk("R5", 32'(running_prio), 32'h80);

        // R10: quiet cycles hold state.
        repeat (5) @(negedge clk);
        check_state("R10");

        // R11: both strobes in one cycle.
        @(negedge clk);
        ack_valid = 1'b1; ack_prio = 8'h10; ack_group = 1'b0;
        eoi_valid = 1'b1; eoi_irq = 10'd4; eoi_group = 1'b1; eoi_secure = 1'b1;
        model_eoi(10'd4, 1'b1, 1'b1);
        model_ack(8'h10, 1'b0);
        @(negedge clk);
        ack_valid = 1'b0; eoi_valid = 1'b0;
        check_state("R11");
        chk("R11", 32'(running_prio), 32'h10);
        drain();

        // Mixed pseudo-random nesting, including rejected completions.
        for (int n = 0; n < 600; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (n % 97 == 0) begin
                @(negedge clk);
                groups_en = lf[4]; sec_ext = lf[5]; cbpr = lf[6];
                bpr_g0 = lf[9:7]; bpr_g1 = lf[12:10];
            end
            if (lf[0] && $countones(m_s | m_ns) < 8)
                do_ack(lf[15:8], lf[1], "R4");
            else
                do_eoi((lf[3:2] == 2'd0) ? 10'd100 : 10'(lf[7:4]), lf[1], lf[2] | lf[3], "R6");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule